// File: doc/BRIEF.md
# Distributed-slot PWM audio generator

This block turns a 10-bit audio sample into a single-wire pulse-width output. A plain PWM would place all the high time in one run at the start of the period. This block splits the sample into a coarse part and a fine part and spreads the high time over 32 groups, so the pin's energy repeats 32 times in each sample period. That raises the effective pulse rate to 32 times the sample rate and makes the analog filter after the pin much easier to build.

A base tick enable sets the slot timing. One slot lasts one tick at the fast rate and two ticks at the slow rate. At the fast rate the 1024 active slots are followed by a forced-low tail of 256 ticks, so the active part is 4/5 of the period. At the slow rate the active part fills the whole period.

The host writes a sample through a one-word write port, and a separate input selects the rate. Both are captured only at the boundary between two periods.

The sequencer is a state machine with three states:
- SEQ_FINE: the first slot of a group.
- SEQ_COARSE: the remaining slots of that group.
- SEQ_TAIL: the forced-low tail, used only at the fast rate.

It has four transitions:
- SEQ_FINE to SEQ_COARSE, on each slot step.
- SEQ_COARSE to SEQ_FINE, at the end of any group except the last one, and also at the end of the last group at the slow rate. The second case is a period wrap.
- SEQ_COARSE to SEQ_TAIL, at the end of the last group at the fast rate.
- SEQ_TAIL to SEQ_FINE, on the last tail tick. This is a period wrap.

Top module: `slotpwm_top`

## Requirements
- R1: Reset drives pwm_out low. Reset also clears the held sample to zero and selects the fast rate, so the whole first period after reset stays low.
- R2: Bits [9:5] of the written word form the coarse count H, and bits [4:0] form the fine count L. For example, 0x13A gives H = 9 and L = 26.
- R3: The first slot of group g (g = 0..31) is high exactly when g < L. Exactly L groups are affected, and they are the lowest-numbered ones.
- R4: Slot s = 1..31 of every group is high exactly when s <= H. This gives exactly H high slots out of 31, placed right after the first slot.
- R5: With rate_sel = 0 (fast), each slot lasts one tick, and the 1024 active slots are followed by 256 ticks of forced low. The period is 1280 ticks.
- R6: With rate_sel = 1 (slow), each slot lasts two ticks and there is no tail. The period is 2048 ticks.
- R7: A write goes to a holding register, and the last write before a period wrap wins. The held word and rate_sel are sampled on the tick that ends a period. They shape only the following period and never the one in progress.
- R8: While tick_en is low, the position in the period and pwm_out hold their values.
- R9: The extremes follow R3 and R4. Word 0x3FF drives 31 of the 32 first slots and all coarse slots high. Word 0x000 keeps the pin low all period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Base slot-rate tick enable |
| wr_en | input | 1 | Write strobe for the sample holding register |
| wr_data | input | 10 | Sample word: coarse field [9:5], fine field [4:0] |
| rate_sel | input | 1 | 0 = fast rate with tail, 1 = slow rate without tail |
| pwm_out | output | 1 | PWM pin |

## Verification
The bench builds the block with its default widths: 5-bit coarse and fine fields, 32 groups of 32 slots, and a 256-tick tail. The real 1280-tick and 2048-tick periods therefore appear in full, and the 0x13A example can be applied as written. The same default widths reach the all-ones and all-zeros fields, and a switch of rate from one period to the next. One period contains both a stalled tick stream and a late overwrite of the held word.

// File: rtl/slotpwm_pkg.sv
package slotpwm_pkg;

    // Position class of the current slot within the sample period.
    typedef enum logic [1:0] {
        SEQ_FINE   = 2'd0,
        SEQ_COARSE = 2'd1,
        SEQ_TAIL   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/slotpwm_shadow.sv
module slotpwm_shadow #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rate_sel,
    input  logic              load,
    output logic [DATA_W-1:0] cur_val,
    output logic              cur_slow
);

    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] cur_q;
    logic              slow_q;

    // Host writes land in pend_q; the period in use reads only cur_q.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            cur_q  <= '0;
            slow_q <= 1'b0;
        end else begin
            if (wr_en) begin
                pend_q <= wr_data;
            end
            if (load) begin
                cur_q  <= pend_q;
                slow_q <= rate_sel;
            end
        end
    end

    assign cur_val  = cur_q;
    assign cur_slow = slow_q;

endmodule

// File: rtl/slotpwm_seq.sv
module slotpwm_seq
    import slotpwm_pkg::*;
#(
    parameter int HI_W       = 5,
    parameter int LO_W       = 5,
    parameter int SLOW_TICKS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            slow,
    output seq_state_e      state,
    output logic [LO_W-1:0] grp,
    output logic [HI_W-1:0] slot,
    output logic            wrap
);

    localparam int ACTIVE_SLOTS = 2 ** (HI_W + LO_W);
    localparam int TAIL_TICKS   = ACTIVE_SLOTS / 4;
    localparam int TAIL_W       = (TAIL_TICKS > 1) ? $clog2(TAIL_TICKS) : 1;
    localparam int SUB_W        = (SLOW_TICKS > 1) ? $clog2(SLOW_TICKS) : 1;
    localparam logic [TAIL_W-1:0] TAIL_LAST = TAIL_W'(TAIL_TICKS - 1);
    localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(SLOW_TICKS - 1);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [LO_W-1:0]   grp_q;
    logic [HI_W-1:0]   slot_q;
    logic [TAIL_W-1:0] tail_q;
    logic [SUB_W-1:0]  sub_q;
    logic              step;
    logic              last_slot;
    logic              last_grp;
    logic              last_tail;
    logic              wrap_d;

    // One slot step per tick at the fast rate, every SLOW_TICKS ticks at the slow rate.
    assign step      = tick_en && (!slow || (sub_q == SUB_LAST));
    assign last_slot = (slot_q == '1);
    assign last_grp  = (grp_q == '1);
    assign last_tail = (tail_q == TAIL_LAST);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_FINE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and period wrap.
    always_comb begin
        state_d = state_q;
        wrap_d  = 1'b0;
        unique case (state_q)
            SEQ_FINE: begin
                if (step) begin
                    state_d = SEQ_COARSE;
                end
            end
            SEQ_COARSE: begin
                if (step && last_slot) begin
                    if (!last_grp) begin
                        state_d = SEQ_FINE;
                    end else if (slow) begin
                        state_d = SEQ_FINE;
                        wrap_d  = 1'b1;
                    end else begin
                        state_d = SEQ_TAIL;
                    end
                end
            end
            SEQ_TAIL: begin
                if (tick_en && last_tail) begin
                    state_d = SEQ_FINE;
                    wrap_d  = 1'b1;
                end
            end
            default: begin
                state_d = SEQ_FINE;
            end
        endcase
    end

    // Position counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q  <= '0;
            slot_q <= '0;
            tail_q <= '0;
            sub_q  <= '0;
        end else if (tick_en) begin
            unique case (state_q)
                SEQ_FINE, SEQ_COARSE: begin
                    if (slow && !step) begin
                        sub_q <= sub_q + 1'b1;
                    end else begin
                        sub_q <= '0;
                    end
                    if (step) begin
                        slot_q <= slot_q + 1'b1;
                        if (last_slot) begin
                            grp_q <= grp_q + 1'b1;
                        end
                    end
                end
                SEQ_TAIL: begin
                    tail_q <= last_tail ? '0 : tail_q + 1'b1;
                end
                default: begin
                    tail_q <= '0;
                end
            endcase
        end
    end

    assign state = state_q;
    assign grp   = grp_q;
    assign slot  = slot_q;
    assign wrap  = wrap_d;

endmodule

// File: rtl/slotpwm_level.sv
module slotpwm_level
    import slotpwm_pkg::*;
#(
    parameter int HI_W = 5,
    parameter int LO_W = 5
) (
    input  seq_state_e            state,
    input  logic [LO_W-1:0]       grp,
    input  logic [HI_W-1:0]       slot,
    input  logic [HI_W+LO_W-1:0]  cur_val,
    output logic                  level
);

    logic [HI_W-1:0] coarse;
    logic [LO_W-1:0] fine;

    assign coarse = cur_val[HI_W+LO_W-1:LO_W];
    assign fine   = cur_val[LO_W-1:0];

    // Output decode from registered position only.
    always_comb begin
        unique case (state)
            SEQ_FINE:   level = (grp < fine);
            SEQ_COARSE: level = (slot <= coarse);
            SEQ_TAIL:   level = 1'b0;
            default:    level = 1'b0;
        endcase
    end

endmodule

// File: rtl/slotpwm_top.sv
module slotpwm_top
    import slotpwm_pkg::*;
#(
    parameter int HI_W       = 5,
    parameter int LO_W       = 5,
    parameter int SLOW_TICKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 wr_en,
    input  logic [HI_W+LO_W-1:0] wr_data,
    input  logic                 rate_sel,
    output logic                 pwm_out
);

    localparam int DATA_W = HI_W + LO_W;

    seq_state_e      seq_state;
    logic [LO_W-1:0] seq_grp;
    logic [HI_W-1:0] seq_slot;
    logic            seq_wrap;
    logic [DATA_W-1:0] cur_val;
    logic            cur_slow;
    logic            level;

    slotpwm_shadow #(
        .DATA_W (DATA_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rate_sel (rate_sel),
        .load     (seq_wrap),
        .cur_val  (cur_val),
        .cur_slow (cur_slow)
    );

    slotpwm_seq #(
        .HI_W       (HI_W),
        .LO_W       (LO_W),
        .SLOW_TICKS (SLOW_TICKS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .slow    (cur_slow),
        .state   (seq_state),
        .grp     (seq_grp),
        .slot    (seq_slot),
        .wrap    (seq_wrap)
    );

    slotpwm_level #(
        .HI_W (HI_W),
        .LO_W (LO_W)
    ) u_level (
        .state   (seq_state),
        .grp     (seq_grp),
        .slot    (seq_slot),
        .cur_val (cur_val),
        .level   (level)
    );

    assign pwm_out = level;

endmodule

// File: rtl/slotpwm_chk.sv
module slotpwm_chk
    import slotpwm_pkg::*;
#(
    parameter int HI_W = 5,
    parameter int LO_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 pwm_out,
    input  seq_state_e           state,
    input  logic [LO_W-1:0]      grp,
    input  logic [HI_W-1:0]      slot,
    input  logic [HI_W+LO_W-1:0] cur_val,
    input  logic                 cur_slow
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_low_chk: assert (!pwm_out);
        end
    end

    // R8
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(pwm_out) && $stable(grp) && $stable(slot)));

    // R7
    load_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_val != $past(cur_val)) |-> (state == SEQ_FINE && grp == '0 && slot == '0));

    // R6
    slow_no_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_slow |-> (state != SEQ_TAIL));

    // R5
    tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_TAIL) |-> !pwm_out);

endmodule

bind slotpwm_top slotpwm_chk #(
    .HI_W (HI_W),
    .LO_W (LO_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .pwm_out  (pwm_out),
    .state    (seq_state),
    .grp      (seq_grp),
    .slot     (seq_slot),
    .cur_val  (cur_val),
    .cur_slow (cur_slow)
);

// File: tb/test_slotpwm_top.sv
`timescale 1ns/1ps
module test_slotpwm_top;

    localparam int HI_W   = 5;
    localparam int LO_W   = 5;
    localparam int GROUPS = 2 ** LO_W;
    localparam int SLOTS  = 2 ** HI_W;
    localparam int TAIL   = (GROUPS * SLOTS) / 4;
    localparam int NPER   = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [9:0] wr_data = '0;
    logic       rate_sel = 1'b0;
    logic       pwm_out;

    always #4 clk = ~clk;

    slotpwm_top i_slotpwm_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rate_sel (rate_sel),
        .pwm_out  (pwm_out)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    exp_q[$];
    string tag_q[$];
    bit    mon_run = 1'b0;
    bit    started = 1'b0;
    bit    last_exp = 1'b0;
    bit    tick_seen = 1'b0;
    bit    done = 1'b0;
    int    pos = 0;

    // Per-period stimulus: word, rate, tag override, late write, tick stall.
    logic [9:0] v_data [NPER];
    bit         v_rate [NPER];
    string      v_tag  [NPER];
    bit         v_late [NPER];
    bit         v_gate [NPER];

    task automatic check(input string tag, input bit act, input bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pwm_out=%0b expected %0b at position %0d", tag, act, exp, pos);
        end
    endtask

    // Expected waveform of one period, built from R3..R6.
    task automatic push_period(input logic [9:0] val, input bit slow, input string over);
        int h;
        int l;
        h = int'(val[9:5]);
        l = int'(val[4:0]);
        for (int g = 0; g < GROUPS; g++) begin
            for (int s = 0; s < SLOTS; s++) begin
                bit    lvl;
                string t;
                lvl = (s == 0) ? (g < l) : (s <= h);
                t = slow ? "R6" : ((s == 0) ? "R3" : "R4");
                if (over != "") t = over;
                for (int r = 0; r < (slow ? 2 : 1); r++) begin
                    exp_q.push_back(lvl);
                    tag_q.push_back(t);
                end
            end
        end
        if (!slow) begin
            for (int i = 0; i < TAIL; i++) begin
                exp_q.push_back(1'b0);
                tag_q.push_back("R5");
            end
        end
    endtask

    always @(posedge clk) tick_seen <= tick_en;

    // Monitor: one expected level per advancing tick, frozen level otherwise.
    always @(negedge clk) begin
        if (mon_run) begin
            if (!started || tick_seen) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R7: pwm_out=%0b expected no further samples", pwm_out);
                end else begin
                    bit    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, pwm_out, e);
                    last_exp = e;
                    pos++;
                end
                started = 1'b1;
            end else begin
                check("R8", pwm_out, last_exp);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8: watchdog expired, actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int len;
        int cnt;
        int hold;
        bit gated;
        bit lw;

        v_data[0] = 10'h000; v_rate[0] = 1'b0; v_tag[0] = "R1"; v_late[0] = 0; v_gate[0] = 0;
        v_data[1] = 10'h13A; v_rate[1] = 1'b0; v_tag[1] = "R2"; v_late[1] = 0; v_gate[1] = 0;
        v_data[2] = 10'h3FF; v_rate[2] = 1'b0; v_tag[2] = "R9"; v_late[2] = 0; v_gate[2] = 0;
        v_data[3] = 10'h021; v_rate[3] = 1'b1; v_tag[3] = "";   v_late[3] = 0; v_gate[3] = 0;
        v_data[4] = 10'h3E0; v_rate[4] = 1'b1; v_tag[4] = "R7"; v_late[4] = 0; v_gate[4] = 1;
        v_data[5] = 10'h01F; v_rate[5] = 1'b0; v_tag[5] = "R7"; v_late[5] = 1; v_gate[5] = 0;
        v_data[6] = 10'h000; v_rate[6] = 1'b0; v_tag[6] = "R9"; v_late[6] = 0; v_gate[6] = 0;

        // R1: pin low while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", pwm_out, 1'b0);

        @(posedge clk);
        #1;
        rst_n   = 1'b1;
        tick_en = 1'b1;
        push_period(v_data[0], v_rate[0], v_tag[0]);
        mon_run = 1'b1;

        for (int k = 0; k < NPER; k++) begin
            if (k + 1 < NPER) begin
                rate_sel = v_rate[k+1];
                wr_en    = 1'b1;
                wr_data  = v_late[k+1] ? 10'h2AA : v_data[k+1];
                push_period(v_data[k+1], v_rate[k+1], v_tag[k+1]);
            end
            len   = v_rate[k] ? GROUPS * SLOTS * 2 : GROUPS * SLOTS + TAIL;
            cnt   = 0;
            hold  = 0;
            gated = 1'b0;
            lw    = 1'b0;
            while (cnt < len) begin
                @(posedge clk);
                if (tick_en) cnt++;
                #1;
                wr_en = 1'b0;
                if (v_gate[k] && cnt == 701 && !gated) begin
                    tick_en = 1'b0;
                    hold    = 6;
                    gated   = 1'b1;
                end else if (hold > 0) begin
                    hold--;
                    if (hold == 0) tick_en = 1'b1;
                end
                if (k + 1 < NPER && v_late[k+1] && cnt == 1500 && !lw) begin
                    wr_en   = 1'b1;
                    wr_data = v_data[k+1];
                    lw      = 1'b1;
                end
            end
        end

        mon_run = 1'b0;
        // R7: every expected sample was consumed exactly at the final wrap
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R7: %0d samples left, expected 0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule